// File: doc/BRIEF.md
# Register Predication Map

This block keeps a small key-value table that marks individual destination registers as predicated, and for each one names the integer register whose contents act as the element mask. Either register bank can be the target: a selector bit in every entry says whether the named target is an integer or a floating-point register. The block converts the table into a per-register view, with one enable bit and one mask-register index per register for each bank. Instruction decode can then answer "is this register predicated, and by which mask?" with a single indexed lookup.

Two independent lookup ports serve decode. Each takes a register index and a bank selector. Each returns the predication flag and the mask register index. Each also takes the value already read from that mask register and an element number. From these it derives the effective mask, the enable bit for that element, and the write data for the element. A masked-off element keeps its old destination value and is not written with zero. Reading the register file and decoding the CSR address are done outside this block.

Top module: `regpred_map`

## Requirements
- R1: The table has 16 entries. With `tbl_we_i` high at a rising clock edge, entry `tbl_addr_i` takes `tbl_wdata_i`. The entry fields are: bits 4:0 target register index, bit 5 bank selector (0 integer, 1 floating-point), bit 6 enable, bits 11:7 mask register index.
- R2: A lookup returns `lk_pred_o`=1 and `lk_midx_o` equal to the entry's mask index when an enabled entry names the looked-up register in the selected bank. An entry for the same index in the other bank has no effect on the lookup.
- R3: When several enabled entries name the same register in the same bank, the entry with the highest table position supplies the mask index.
- R4: A table write is not visible at the lookup ports after the first rising edge that stores it. It is visible after the second rising edge.
- R5: For a predicated lookup, `lk_eff_o` equals `lk_mask_i`, and `lk_elem_en_o` equals bit `lk_elem_i` of `lk_mask_i`.
- R6: `lk_res_o` equals `lk_new_i` when the element is enabled. Otherwise it equals `lk_old_i`, so the destination is left unchanged and is never zeroed.
- R7: A lookup on a register with no enabled entry returns `lk_pred_o`=0, `lk_midx_o`=0, `lk_eff_o` all ones and `lk_elem_en_o`=1.
- R8: Reset (`rst_ni` low) clears every table entry, so no register is predicated.
- R9: Rewriting an entry with its enable bit at 0 removes the predication that entry had applied.
- R10: The two lookup ports are independent. Each port's outputs depend only on the table and on that port's own inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_addr_i | input | 4 | Table entry to write |
| tbl_wdata_i | input | 12 | Entry value (layout in R1) |
| lk_reg_i | input | 2x5 | Register index per lookup port |
| lk_fp_i | input | 2 | Bank selector per port (1 = floating-point) |
| lk_mask_i | input | 2x64 | Mask register value per port |
| lk_elem_i | input | 2x6 | Element number per port |
| lk_old_i | input | 2x64 | Current destination element value per port |
| lk_new_i | input | 2x64 | Computed element value per port |
| lk_pred_o | output | 2 | Register is predicated |
| lk_midx_o | output | 2x5 | Mask register index (0 when not predicated) |
| lk_eff_o | output | 2x64 | Effective mask (all ones when not predicated) |
| lk_elem_en_o | output | 2 | Selected element is enabled |
| lk_res_o | output | 2x64 | Element write data after gating |

## Verification
The lookup results are combinational from the derived arrays, so they are due in the same cycle the port inputs change. The bench drives those inputs on the falling edge and samples a few nanoseconds later, in the same low phase. A table write passes through two registers: the table itself, then the derived arrays. The bench therefore checks the old result one falling edge after the write strobe and the new result one falling edge after that. Every other table change gets two full edges before any lookup against it is sampled.

// File: rtl/regpred_pkg.sv
package regpred_pkg;
  localparam int TGT_W    = 5;
  localparam int MIDX_W   = 5;
  localparam int NUM_REGS = 1 << TGT_W;

  // field order fixed: decode writes raw words with this layout
  typedef struct packed {
    logic [MIDX_W-1:0] midx;
    logic              en;
    logic              fp;
    logic [TGT_W-1:0]  tgt;
  } pred_entry_t;

  localparam int ENTRY_W = $bits(pred_entry_t);
endpackage

// File: rtl/regpred_table.sv
module regpred_table
  import regpred_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int AW = $clog2(NUM_ENTRIES)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [AW-1:0]                 addr_i,
  input  pred_entry_t                   data_i,
  output pred_entry_t [NUM_ENTRIES-1:0] tbl_o
);
  pred_entry_t [NUM_ENTRIES-1:0] tbl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbl_q <= '0;
    end else if (we_i) begin
      tbl_q[addr_i] <= data_i;
    end
  end

  assign tbl_o = tbl_q;
endmodule

// File: rtl/regpred_invert.sv
module regpred_invert
  import regpred_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  pred_entry_t [NUM_ENTRIES-1:0]       tbl_i,
  output logic [NUM_REGS-1:0]                 int_en_o,
  output logic [NUM_REGS-1:0][MIDX_W-1:0]     int_idx_o,
  output logic [NUM_REGS-1:0]                 fp_en_o,
  output logic [NUM_REGS-1:0][MIDX_W-1:0]     fp_idx_o
);
  logic [NUM_REGS-1:0]             int_en_d, fp_en_d;
  logic [NUM_REGS-1:0][MIDX_W-1:0] int_idx_d, fp_idx_d;

  // ascending scan: later entries overwrite earlier ones
  always_comb begin
    int_en_d  = '0;
    int_idx_d = '0;
    fp_en_d   = '0;
    fp_idx_d  = '0;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      if (tbl_i[e].en) begin
        if (tbl_i[e].fp) begin
          fp_en_d[tbl_i[e].tgt]  = 1'b1;
          fp_idx_d[tbl_i[e].tgt] = tbl_i[e].midx;
        end else begin
          int_en_d[tbl_i[e].tgt]  = 1'b1;
          int_idx_d[tbl_i[e].tgt] = tbl_i[e].midx;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_en_o  <= '0;
      int_idx_o <= '0;
      fp_en_o   <= '0;
      fp_idx_o  <= '0;
    end else begin
      int_en_o  <= int_en_d;
      int_idx_o <= int_idx_d;
      fp_en_o   <= fp_en_d;
      fp_idx_o  <= fp_idx_d;
    end
  end
endmodule

// File: rtl/regpred_lookup.sv
module regpred_lookup
  import regpred_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int EW = $clog2(XLEN)
) (
  input  logic [NUM_REGS-1:0]             int_en_i,
  input  logic [NUM_REGS-1:0][MIDX_W-1:0] int_idx_i,
  input  logic [NUM_REGS-1:0]             fp_en_i,
  input  logic [NUM_REGS-1:0][MIDX_W-1:0] fp_idx_i,
  input  logic [TGT_W-1:0]                reg_i,
  input  logic                            fp_i,
  input  logic [XLEN-1:0]                 mask_i,
  input  logic [EW-1:0]                   elem_i,
  input  logic [XLEN-1:0]                 old_i,
  input  logic [XLEN-1:0]                 new_i,
  output logic                            pred_o,
  output logic [MIDX_W-1:0]               midx_o,
  output logic [XLEN-1:0]                 eff_o,
  output logic                            elem_en_o,
  output logic [XLEN-1:0]                 res_o
);
  logic              hit;
  logic [MIDX_W-1:0] idx_sel;

  always_comb begin
    hit       = fp_i ? fp_en_i[reg_i]  : int_en_i[reg_i];
    idx_sel   = fp_i ? fp_idx_i[reg_i] : int_idx_i[reg_i];
    pred_o    = hit;
    midx_o    = hit ? idx_sel : '0;
    eff_o     = hit ? mask_i : '1;
    elem_en_o = eff_o[elem_i];
    // masked-off element keeps prior contents
    res_o     = elem_en_o ? new_i : old_i;
  end
endmodule

// File: rtl/regpred_map.sv
module regpred_map
  import regpred_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_PORTS   = 2,
  parameter int XLEN        = 64,
  localparam int AW = $clog2(NUM_ENTRIES),
  localparam int EW = $clog2(XLEN)
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 tbl_we_i,
  input  logic [AW-1:0]                        tbl_addr_i,
  input  logic [ENTRY_W-1:0]                   tbl_wdata_i,
  input  logic [NUM_PORTS-1:0][TGT_W-1:0]      lk_reg_i,
  input  logic [NUM_PORTS-1:0]                 lk_fp_i,
  input  logic [NUM_PORTS-1:0][XLEN-1:0]       lk_mask_i,
  input  logic [NUM_PORTS-1:0][EW-1:0]         lk_elem_i,
  input  logic [NUM_PORTS-1:0][XLEN-1:0]       lk_old_i,
  input  logic [NUM_PORTS-1:0][XLEN-1:0]       lk_new_i,
  output logic [NUM_PORTS-1:0]                 lk_pred_o,
  output logic [NUM_PORTS-1:0][MIDX_W-1:0]     lk_midx_o,
  output logic [NUM_PORTS-1:0][XLEN-1:0]       lk_eff_o,
  output logic [NUM_PORTS-1:0]                 lk_elem_en_o,
  output logic [NUM_PORTS-1:0][XLEN-1:0]       lk_res_o
);
  pred_entry_t [NUM_ENTRIES-1:0]   tbl;
  logic [NUM_REGS-1:0]             int_en, fp_en;
  logic [NUM_REGS-1:0][MIDX_W-1:0] int_idx, fp_idx;

  regpred_table #(.NUM_ENTRIES(NUM_ENTRIES)) u_table (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (tbl_we_i),
    .addr_i (tbl_addr_i),
    .data_i (pred_entry_t'(tbl_wdata_i)),
    .tbl_o  (tbl)
  );

  regpred_invert #(.NUM_ENTRIES(NUM_ENTRIES)) u_invert (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tbl_i     (tbl),
    .int_en_o  (int_en),
    .int_idx_o (int_idx),
    .fp_en_o   (fp_en),
    .fp_idx_o  (fp_idx)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    regpred_lookup #(.XLEN(XLEN)) u_lookup (
      .int_en_i  (int_en),
      .int_idx_i (int_idx),
      .fp_en_i   (fp_en),
      .fp_idx_i  (fp_idx),
      .reg_i     (lk_reg_i[p]),
      .fp_i      (lk_fp_i[p]),
      .mask_i    (lk_mask_i[p]),
      .elem_i    (lk_elem_i[p]),
      .old_i     (lk_old_i[p]),
      .new_i     (lk_new_i[p]),
      .pred_o    (lk_pred_o[p]),
      .midx_o    (lk_midx_o[p]),
      .eff_o     (lk_eff_o[p]),
      .elem_en_o (lk_elem_en_o[p]),
      .res_o     (lk_res_o[p])
    );
  end
endmodule

// File: rtl/regpred_map_chk.sv
module regpred_map_chk
  import regpred_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int XLEN      = 64,
  localparam int EW = $clog2(XLEN)
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic [NUM_PORTS-1:0][XLEN-1:0]   lk_mask_i,
  input logic [NUM_PORTS-1:0][EW-1:0]     lk_elem_i,
  input logic [NUM_PORTS-1:0][XLEN-1:0]   lk_old_i,
  input logic [NUM_PORTS-1:0][XLEN-1:0]   lk_new_i,
  input logic [NUM_PORTS-1:0]             lk_pred_o,
  input logic [NUM_PORTS-1:0][MIDX_W-1:0] lk_midx_o,
  input logic [NUM_PORTS-1:0][XLEN-1:0]   lk_eff_o,
  input logic [NUM_PORTS-1:0]             lk_elem_en_o,
  input logic [NUM_PORTS-1:0][XLEN-1:0]   lk_res_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    a_r6_hold_old: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lk_elem_en_o[p] |-> lk_res_o[p] == lk_old_i[p]);
    a_r6_take_new: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lk_elem_en_o[p] |-> lk_res_o[p] == lk_new_i[p]);
    a_r5_elem_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lk_pred_o[p] |-> lk_elem_en_o[p] == lk_mask_i[p][lk_elem_i[p]]);
    a_r7_all_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lk_pred_o[p] |-> (lk_eff_o[p] == '1) && lk_elem_en_o[p]);
    a_r7_zero_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lk_pred_o[p] |-> lk_midx_o[p] == '0);
  end
endmodule

bind regpred_map regpred_map_chk #(.NUM_PORTS(NUM_PORTS), .XLEN(XLEN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lk_mask_i    (lk_mask_i),
  .lk_elem_i    (lk_elem_i),
  .lk_old_i     (lk_old_i),
  .lk_new_i     (lk_new_i),
  .lk_pred_o    (lk_pred_o),
  .lk_midx_o    (lk_midx_o),
  .lk_eff_o     (lk_eff_o),
  .lk_elem_en_o (lk_elem_en_o),
  .lk_res_o     (lk_res_o)
);

// File: tb/regpred_map_bench.sv
module regpred_map_bench;
  localparam logic [63:0] MASK  = 64'h8000_0000_0000_0005;
  localparam logic [63:0] OLDV  = 64'h1111_2222_3333_4444;
  localparam logic [63:0] NEWV  = 64'hAAAA_BBBB_CCCC_DDDD;
  localparam int          NVEC  = 12;
  // {reg[18:14], fp[13], elem[12:7], pred[6], midx[5:1], en[0]}
  localparam logic [18:0] VEC [NVEC] = '{
    {5'd3,  1'b0, 6'd0,  1'b1, 5'd10, 1'b1},
    {5'd3,  1'b0, 6'd1,  1'b1, 5'd10, 1'b0},
    {5'd3,  1'b1, 6'd1,  1'b1, 5'd11, 1'b0},
    {5'd7,  1'b0, 6'd2,  1'b1, 5'd20, 1'b1},
    {5'd7,  1'b1, 6'd2,  1'b0, 5'd0,  1'b1},
    {5'd9,  1'b0, 6'd1,  1'b0, 5'd0,  1'b1},
    {5'd31, 1'b1, 6'd63, 1'b1, 5'd1,  1'b1},
    {5'd31, 1'b1, 6'd62, 1'b1, 5'd1,  1'b0},
    {5'd31, 1'b0, 6'd62, 1'b0, 5'd0,  1'b1},
    {5'd0,  1'b0, 6'd5,  1'b1, 5'd2,  1'b0},
    {5'd0,  1'b1, 6'd5,  1'b0, 5'd0,  1'b1},
    {5'd12, 1'b0, 6'd1,  1'b0, 5'd0,  1'b1}
  };

  logic                  clk = 1'b0;
  logic                  rst_ni = 1'b0;
  logic                  tbl_we = 1'b0;
  logic [3:0]            tbl_addr = '0;
  logic [11:0]           tbl_wdata = '0;
  logic [1:0][4:0]       lk_reg = '0;
  logic [1:0]            lk_fp = '0;
  logic [1:0][63:0]      lk_mask = '0;
  logic [1:0][5:0]       lk_elem = '0;
  logic [1:0][63:0]      lk_old = '0;
  logic [1:0][63:0]      lk_new = '0;
  logic [1:0]            lk_pred;
  logic [1:0][4:0]       lk_midx;
  logic [1:0][63:0]      lk_eff;
  logic [1:0]            lk_elem_en;
  logic [1:0][63:0]      lk_res;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  regpred_map u_regpred_map (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .tbl_we_i     (tbl_we),
    .tbl_addr_i   (tbl_addr),
    .tbl_wdata_i  (tbl_wdata),
    .lk_reg_i     (lk_reg),
    .lk_fp_i      (lk_fp),
    .lk_mask_i    (lk_mask),
    .lk_elem_i    (lk_elem),
    .lk_old_i     (lk_old),
    .lk_new_i     (lk_new),
    .lk_pred_o    (lk_pred),
    .lk_midx_o    (lk_midx),
    .lk_eff_o     (lk_eff),
    .lk_elem_en_o (lk_elem_en),
    .lk_res_o     (lk_res)
  );

  function automatic logic [11:0] mk(logic en, logic fp, logic [4:0] tgt, logic [4:0] midx);
    return {midx, en, fp, tgt};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tbl_wr(logic [3:0] a, logic [11:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = a; tbl_wdata = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic drive(int p, logic [4:0] r, logic fp, logic [5:0] e);
    lk_reg[p] = r; lk_fp[p] = fp; lk_elem[p] = e;
    lk_mask[p] = MASK; lk_old[p] = OLDV; lk_new[p] = NEWV;
  endtask

  task automatic check_vec(int p, logic [18:0] v);
    logic       ep;
    logic [4:0] em;
    logic       ee;
    ep = v[6]; em = v[5:1]; ee = v[0];
    chk(ep ? "R2 pred" : "R7 pred", 64'(lk_pred[p]), 64'(ep));
    chk("R2 midx (R1 field)", 64'(lk_midx[p]), 64'(em));
    chk(ep ? "R5 eff" : "R7 eff", lk_eff[p], ep ? MASK : '1);
    chk(ep ? "R5 elem_en" : "R7 elem_en", 64'(lk_elem_en[p]), 64'(ee));
    chk("R6 res", lk_res[p], ee ? NEWV : OLDV);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    drive(0, 5'd3, 1'b0, 6'd0);
    drive(1, 5'd31, 1'b1, 6'd1);
    repeat (3) @(negedge clk);
    #2;
    // R8: reset state
    chk("R8 reset pred", 64'(lk_pred), 64'd0);
    chk("R8 reset eff", lk_eff[0], '1);
    rst_ni = 1'b1;

    tbl_wr(4'd0,  mk(1'b1, 1'b0, 5'd3,  5'd10));
    tbl_wr(4'd1,  mk(1'b1, 1'b1, 5'd3,  5'd11));
    tbl_wr(4'd2,  mk(1'b1, 1'b0, 5'd7,  5'd12));
    tbl_wr(4'd9,  mk(1'b1, 1'b0, 5'd7,  5'd20));
    tbl_wr(4'd5,  mk(1'b0, 1'b0, 5'd9,  5'd13));
    tbl_wr(4'd15, mk(1'b1, 1'b1, 5'd31, 5'd1));
    tbl_wr(4'd4,  mk(1'b1, 1'b0, 5'd0,  5'd2));
    settle();

    // vector walk: R10 via different vectors on each port
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      drive(0, VEC[i][18:14], VEC[i][13], VEC[i][12:7]);
      drive(1, VEC[(i+5)%NVEC][18:14], VEC[(i+5)%NVEC][13], VEC[(i+5)%NVEC][12:7]);
      #2;
      check_vec(0, VEC[i]);
      check_vec(1, VEC[(i+5)%NVEC]);
    end

    // R3: entry 9 overrides entry 2 for integer r7
    @(negedge clk);
    drive(0, 5'd7, 1'b0, 6'd0);
    #2;
    chk("R3 priority midx", 64'(lk_midx[0]), 64'd20);

    // R4: latency of a new entry
    drive(0, 5'd20, 1'b0, 6'd2);
    drive(1, 5'd20, 1'b1, 6'd2);
    tbl_wr(4'd6, mk(1'b1, 1'b0, 5'd20, 5'd5));
    #2;
    chk("R4 not yet visible", 64'(lk_pred[0]), 64'd0);
    @(negedge clk);
    #2;
    chk("R4 visible pred", 64'(lk_pred[0]), 64'd1);
    chk("R4 visible midx", 64'(lk_midx[0]), 64'd5);
    chk("R2 other bank unaffected", 64'(lk_pred[1]), 64'd0);

    // R9: disabling the entry removes predication
    tbl_wr(4'd6, mk(1'b0, 1'b0, 5'd20, 5'd5));
    settle();
    #2;
    chk("R9 disabled pred", 64'(lk_pred[0]), 64'd0);
    chk("R9 disabled eff", lk_eff[0], '1);

    // R8: asynchronous reset mid-run clears table
    @(negedge clk);
    drive(0, 5'd3, 1'b0, 6'd1);
    #2;
    chk("R8 before reset pred", 64'(lk_pred[0]), 64'd1);
    rst_ni = 1'b0;
    #2;
    chk("R8 in reset pred", 64'(lk_pred[0]), 64'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    settle();
    #2;
    chk("R8 after reset pred", 64'(lk_pred[0]), 64'd0);
    chk("R8 after reset res", lk_res[0], NEWV);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule